// File: doc/BRIEF.md
# Serial-Loaded Converter Code Register

This block is the digital front end of a serial-input digital-to-analog converter. A host sends a code over three wires: an active-low select, a data line and a serial clock. While select is low, every rising serial clock edge pushes one data bit into a shift register, most significant bit first. When select returns high, the shift register contents are copied into a holding register. The holding register drives the converter code, and a one-cycle strobe marks each new value.

The three serial pins are asynchronous to the system clock. They pass through a synchroniser, and edges are detected in the system clock domain, where all state lives. Frames of any length are accepted. The load is triggered by the rising edge of select, not by a bit count, so the last WIDTH bits clocked in always win. A 14-bit build therefore accepts a 16-clock frame and drops its two earliest bits. A short frame still loads, and its upper bits come from whatever the shift register already held.

Top module: `ser_code_latch`

## Requirements
- R1: While rst_ni is low, code_o is 0 and update_o is 0. Both stay there until the first completed frame after reset is released.
- R2: While cs_ni is low, each rising edge of sclk_i samples sdi_i into the shift register, most significant bit first. After exactly WIDTH clocks, the loaded code equals the word sent.
- R3: While cs_ni is high, edges on sclk_i leave the shift register unchanged. A following frame with zero clocks loads the same code as before.
- R4: code_o changes only as a result of a rising edge on cs_ni. It stays constant during a frame while bits are being shifted.
- R5: When a frame carries more than WIDTH clocks, only the last WIDTH bits are loaded and earlier bits are discarded.
- R6: With WIDTH = 14, a 16-clock frame loads the final 14 bits, so bits 15 and 14 of the sent word are dropped.
- R7: A frame with fewer than WIDTH clocks still loads on the select edge. The code is the previous shift contents moved up by the number of clocks, with the new bits in the low positions.
- R8: update_o is high for exactly one system clock per rising edge of cs_ni.
- R9: code_o and update_o take their new values on the (SYNC_STAGES+1)-th rising edge of clk_i after cs_ni rises, which is the 3rd edge with the default setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low frame select; its rising edge loads the code |
| sdi_i | input | 1 | Serial data, MSB first |
| sclk_i | input | 1 | Serial clock; rising edge samples sdi_i |
| code_o | output | WIDTH | Latched converter code |
| update_o | output | 1 | One-cycle strobe when code_o is loaded |

## Verification
Every serial pin goes through SYNC_STAGES synchroniser flops and then one edge-detect stage. The register load therefore lands on the third system clock edge after cs_ni rises. The bench drives inputs on falling edges and samples on the falling edges that follow. It requires update_o low at the second and fourth of those samples and high at the third, with the new code already present. Serial data is held for three system cycles on each side of every sclk_i edge. This keeps a bit stable through the synchroniser when its clock edge is detected. The bench also checks that the old code is still present just before select rises.

// File: rtl/ser_code_pkg.sv
package ser_code_pkg;
  typedef struct packed {
    logic sel_n;
    logic dat;
    logic sck;
  } ser_pins_t;

  localparam ser_pins_t PINS_IDLE = '{sel_n: 1'b1, dat: 1'b0, sck: 1'b0};
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] d_stage;
    if (g == 0) begin : g_first
      assign d_stage = d_i;
    end else begin : g_next
      assign d_stage = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else         stage_q[g] <= d_stage;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_det.sv
module edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] word_q;

  // oldest bits fall off the top, so the last WIDTH bits always win
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= '0;
    else if (shift_en_i) word_q <= {word_q[WIDTH-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/hold_unit.sv
module hold_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] code_o,
  output logic             update_o
);
  logic [WIDTH-1:0] code_q;
  logic             upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) code_q <= word_i;
    end
  end

  assign code_o   = code_q;
  assign update_o = upd_q;
endmodule

// File: rtl/ser_code_latch.sv
module ser_code_latch
  import ser_code_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sdi_i,
  input  logic             sclk_i,
  output logic [WIDTH-1:0] code_o,
  output logic             update_o
);
  localparam int PW = $bits(ser_pins_t);

  ser_pins_t        pins_raw;
  ser_pins_t        pins_s;
  logic [PW-1:0]    sync_vec;
  logic             sel_s, dat_s, sck_s;
  logic             sck_rise, sel_rise, shift_en;
  logic [WIDTH-1:0] shift_q;

  assign pins_raw = '{sel_n: cs_ni, dat: sdi_i, sck: sclk_i};

  pin_sync #(
    .STAGES (SYNC_STAGES),
    .W      (PW),
    .RST_VAL(PINS_IDLE)
  ) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (sync_vec)
  );

  assign pins_s = ser_pins_t'(sync_vec);
  assign sel_s  = pins_s.sel_n;
  assign dat_s  = pins_s.dat;
  assign sck_s  = pins_s.sck;

  edge_det #(.RST_VAL(1'b0)) i_sck_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sck_s),
    .rise_o(sck_rise)
  );

  edge_det #(.RST_VAL(1'b1)) i_sel_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sel_s),
    .rise_o(sel_rise)
  );

  assign shift_en = sck_rise & ~sel_s;

  shift_unit #(.WIDTH(WIDTH)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .bit_i     (dat_s),
    .word_o    (shift_q)
  );

  hold_unit #(.WIDTH(WIDTH)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sel_rise),
    .word_i  (shift_q),
    .code_o  (code_o),
    .update_o(update_o)
  );
endmodule

// File: rtl/ser_code_latch_chk.sv
module ser_code_latch_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic [WIDTH-1:0] code_o,
  input logic             update_o,
  input logic             sel_s,
  input logic             dat_s,
  input logic             sck_rise,
  input logic [WIDTH-1:0] shift_q
);
  assert_sample_msb_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && !sel_s) |=> shift_q[0] == $past(dat_s));

  assert_shift_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_s |=> $stable(shift_q));

  assert_code_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(code_o));

  assert_code_from_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> code_o == $past(shift_q));

  assert_single_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  assert_strobe_after_select_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (cs_ni && $past(cs_ni)));
endmodule

bind ser_code_latch ser_code_latch_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .code_o  (code_o),
  .update_o(update_o),
  .sel_s   (sel_s),
  .dat_s   (dat_s),
  .sck_rise(sck_rise),
  .shift_q (shift_q)
);

// File: tb/test_ser_code_latch.sv
`timescale 1ns/1ps
module test_ser_code_latch;
  localparam int W16 = 16;
  localparam int W14 = 14;
  localparam int NVEC = 8;
  localparam logic [31:0] V_BITS [NVEC] = '{
    32'h0000_A5C3, 32'h0000_0001, 32'h0000_FFFF, 32'h0000_8000,
    32'h000F_1234, 32'h00AB_CDEF, 32'h0000_005A, 32'h0000_3C3C};
  localparam int V_LEN [NVEC] = '{16, 16, 16, 16, 20, 24, 8, 16};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sclk = 1'b0;
  logic [W16-1:0] code16;
  logic [W14-1:0] code14;
  logic upd16, upd14;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W16-1:0] sh16 = '0, exp16 = '0;
  logic [W14-1:0] sh14 = '0, exp14 = '0;

  always #2.5 clk = ~clk;

  ser_code_latch #(.WIDTH(W16)) i_ser_code_latch (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sdi_i(sdi), .sclk_i(sclk),
    .code_o(code16), .update_o(upd16));

  ser_code_latch #(.WIDTH(W14)) i_ser_code_latch_w14 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sdi_i(sdi), .sclk_i(sclk),
    .code_o(code14), .update_o(upd14));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    waitn(3);
    sclk = 1'b1;
    sh16 = {sh16[W16-2:0], b};
    sh14 = {sh14[W14-2:0], b};
    waitn(3);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [31:0] bits, input int len, input string req);
    cs_n = 1'b0;
    waitn(3);
    for (int i = len - 1; i >= 0; i--) send_bit(bits[i]);
    waitn(3);
    chk(code16 == exp16, "R4 code stable in frame", 32'(code16), 32'(exp16));
    exp16 = sh16;
    exp14 = sh14;
    cs_n = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      waitn(1);
      chk(upd16 == (k == 3), "R8 strobe width", 32'(upd16), 32'(k == 3));
      if (k == 2) chk(code16 != exp16 || upd16 == 1'b0, "R9 no early load", 32'(code16), 32'(exp16));
      if (k == 3) begin
        chk(code16 == exp16, req, 32'(code16), 32'(exp16));
        chk(upd14 == 1'b1, "R9 strobe on third edge", 32'(upd14), 32'd1);
        chk(code14 == exp14, "R6 narrow build code", 32'(code14), 32'(exp14));
      end
    end
    waitn(4);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    waitn(3);
    chk(code16 == '0 && upd16 == 1'b0, "R1 reset state", 32'(code16), 32'd0);
    rst_n = 1'b1;
    waitn(4);
    chk(code16 == '0 && code14 == '0, "R1 after release", 32'(code16), 32'd0);

    // table walk: exact, long and short frames
    for (int v = 0; v < NVEC; v++) begin
      frame(V_BITS[v], V_LEN[v],
            V_LEN[v] > W16 ? "R5 last bits win" : (V_LEN[v] < W16 ? "R7 short frame" : "R2 exact frame"));
    end

    // R3: clocks with select high must not disturb the shift register
    for (int i = 0; i < 5; i++) begin
      sdi = i[0];
      waitn(3);
      sclk = 1'b1;
      waitn(3);
      sclk = 1'b0;
    end
    waitn(4);
    chk(code16 == exp16 && upd16 == 1'b0, "R3 code unchanged by idle clocks", 32'(code16), 32'(exp16));
    frame(32'h0, 0, "R3 empty frame reloads held shift");

    // R6: explicit 16-clock frame on narrow build drops two earliest bits
    frame(32'h0000_C001, 16, "R2 exact frame");
    chk(code14 == 14'h0001, "R6 top bits dropped", 32'(code14), 32'h1);

    // R1: reset in mid-run
    rst_n = 1'b0;
    sh16 = '0; sh14 = '0; exp16 = '0; exp14 = '0;
    waitn(2);
    chk(code16 == '0 && code14 == '0 && upd16 == 1'b0, "R1 mid-run reset", 32'(code16), 32'd0);
    rst_n = 1'b1;
    waitn(4);
    frame(32'h0000_0003, 4, "R7 short frame after reset");
    chk(code16 == 16'h0003, "R7 zero upper bits", 32'(code16), 32'h3);

    finish_run();
  end
endmodule